// File: doc/BRIEF.md
# Serial Memory Slave Command Engine

This block is the slave side of a byte-addressed serial memory on a four-wire serial bus. The bus runs in clock mode 0: the idle clock is low, input is taken on the rising clock edge, output changes on the falling edge, and every field goes most significant bit first. The bus clock, the select line and the data input are brought into the system clock domain through a short synchroniser. The engine then works on the clock edges it detects there.

A frame opens when select goes low. The first byte is a command. A memory access carries two address bytes after the command and then data bytes in either direction. An internal 16-bit address counter moves on after every byte, so one frame can stream any number of bytes and wrap around the whole 64K address space. Each written byte goes into an internal RAM as soon as its eighth bit arrives. An external protection unit sees the address of the byte in progress and answers with a permit bit.

A status byte holds the write-enable latch and three bits that software can write. These bits are presented on a port for the protection unit to use.

Top module: `serial_mem_slave`

## Requirements
- R1: Command codes are 06h set write enable, 04h clear write enable, 05h read status, 01h write status, 03h read memory and 02h write memory. Any other first byte is ignored, and so are all later bytes until select goes high.
- R2: The write-enable latch is cleared by reset and by 04h, and set by 06h, each taking effect at the end of its command byte. A memory or status write made while the latch is clear changes nothing.
- R3: A memory write frame is 02h, the high address byte, the low address byte, then data. Each data byte is committed after its eighth rising clock, and a burst has no length limit. A byte cut short by select going high is discarded.
- R4: A memory read frame is 03h followed by two address bytes. The most significant data bit appears on the output after the falling edge that follows the last address bit, and one bit is shifted out per clock after that. The data input is ignored during read data.
- R5: The 16-bit address counter adds one after every data byte of a read or a write, and it wraps from FFFFh to 0000h.
- R6: The RAM holds 2^MEM_AW bytes (1024 by default) and is indexed by the low MEM_AW bits of the address, so higher addresses alias onto it.
- R7: chk_addr shows the address of the data byte in progress. If wr_permit is low when that byte completes, the byte is dropped, but the address counter still advances.
- R8: The status byte has bit 1 for the write-enable latch, and bits 7, 3 and 2 as stored bits. Bits 6, 5, 4 and 0 read as 0. A status write, which needs the latch set, loads only bits 7, 3 and 2 from its first data byte. stat_q shows the status byte, and it is 00h after reset.
- R9: A status read sends the status byte again and again for as long as clocks continue in the frame.
- R10: so_oe is low and so is high impedance while select is high. so_oe is high within a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Bus clock, mode 0 |
| cs_n | input | 1 | Active-low select; a frame lasts while it is low |
| si | input | 1 | Serial data into the block |
| so | output | 1 | Serial data out, high impedance when not selected |
| so_oe | output | 1 | High while so is driven |
| chk_addr | output | 16 | Address of the current data byte, for the protection unit |
| wr_permit | input | 1 | Protection answer for chk_addr: 1 allows the write |
| stat_q | output | 8 | Current status byte |

## Verification
The bench targets the address counter wrapping at FFFFh in both directions. A counter that saturated or reset would return the wrong third and fourth bytes of the burst. It also targets a denied byte in the middle of a burst: a design that failed to advance the counter on a drop would put the next permitted byte at the wrong address. A select that rises in the middle of a byte is checked, because committing that partial byte would overwrite the neighbouring location. The bench also sends unknown commands followed by bytes that look like valid commands, sends nonzero input during read data, and makes status writes with the latch clear. Each of these would show up as a changed memory byte or status byte if the design got it wrong.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   localparam logic [7:0] OP_WRSR  = 8'h01;
   localparam logic [7:0] OP_WRITE = 8'h02;
   localparam logic [7:0] OP_READ  = 8'h03;
   localparam logic [7:0] OP_WRDI  = 8'h04;
   localparam logic [7:0] OP_RDSR  = 8'h05;
   localparam logic [7:0] OP_WREN  = 8'h06;

   localparam logic [7:0] STAT_WR_MASK = 8'h8C;
   localparam int         WEL_POS      = 1;

   typedef enum logic [2:0] {
      PH_CMD, PH_ADH, PH_ADL, PH_RDAT, PH_WDAT, PH_RDSR, PH_WRSR, PH_IDLE
   } phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
   parameter int              WIDTH   = 3,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [STAGES-1:0][WIDTH-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad
         $error("spi_sync needs at least two stages");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[0] <= RST_VAL;
               else        pipe[0] <= din;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) pipe[s] <= RST_VAL;
               else        pipe[s] <= pipe[s-1];
         end
      end
   endgenerate

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
   parameter int AW = 10,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 12) begin : g_bad
         $error("spi_mem_array depth out of range");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
   end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
   import spi_mem_pkg::*;
#(
   parameter int MEM_AW = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_hi,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              si_bit,
   input  logic [7:0]        rd_byte,
   input  logic              wr_permit,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic [15:0]       chk_addr,
   output logic              so_bit,
   output logic [7:0]        stat_q
);
   localparam int ADDR_W = 16;

   generate
      if (MEM_AW > ADDR_W) begin : g_bad
         $error("array address wider than bus address");
      end
   endgenerate

   phase_e            ph_q;
   logic [2:0]        bit_q;
   logic [6:0]        rx_q;
   logic [7:0]        tx_q;
   logic [ADDR_W-1:0] addr_q;
   logic              wel_q;
   logic [7:0]        sbits_q;
   logic              so_q;

   logic [7:0] rx_byte;
   logic       byte_end;
   logic [7:0] src_byte;

   assign rx_byte  = {rx_q, si_bit};
   assign byte_end = sck_rise && (bit_q == 3'd7);
   assign stat_q   = (sbits_q & STAT_WR_MASK) | (8'(wel_q) << WEL_POS);
   assign src_byte = (ph_q == PH_RDSR) ? stat_q : rd_byte;

   assign mem_we    = byte_end && (ph_q == PH_WDAT) && wel_q && wr_permit;
   assign mem_addr  = addr_q[MEM_AW-1:0];
   assign mem_wdata = rx_byte;
   assign chk_addr  = addr_q;
   assign so_bit    = so_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_CMD;
         bit_q   <= '0;
         rx_q    <= '0;
         tx_q    <= '0;
         addr_q  <= '0;
         wel_q   <= 1'b0;
         sbits_q <= '0;
         so_q    <= 1'b0;
      end else if (cs_hi) begin
         ph_q  <= PH_CMD;
         bit_q <= '0;
         tx_q  <= '0;
         so_q  <= 1'b0;
      end else begin
         if (sck_rise) begin
            rx_q  <= rx_byte[6:0];
            bit_q <= 3'(bit_q + 3'd1);
            if (bit_q == 3'd7) begin
               case (ph_q)
                  PH_CMD: begin
                     case (rx_byte)
                        OP_WREN:  begin wel_q <= 1'b1; ph_q <= PH_IDLE; end
                        OP_WRDI:  begin wel_q <= 1'b0; ph_q <= PH_IDLE; end
                        OP_RDSR:  ph_q <= PH_RDSR;
                        OP_WRSR:  ph_q <= PH_WRSR;
                        OP_READ,
                        OP_WRITE: ph_q <= PH_ADH;
                        default:  ph_q <= PH_IDLE;
                     endcase
                     tx_q[0] <= (rx_byte == OP_READ);
                  end
                  PH_ADH: begin
                     addr_q[15:8] <= rx_byte;
                     ph_q         <= PH_ADL;
                  end
                  PH_ADL: begin
                     addr_q[7:0] <= rx_byte;
                     ph_q        <= tx_q[0] ? PH_RDAT : PH_WDAT;
                  end
                  PH_RDAT, PH_WDAT: addr_q <= addr_q + 16'd1;
                  PH_WRSR: begin
                     if (wel_q) sbits_q <= rx_byte & STAT_WR_MASK;
                     ph_q <= PH_IDLE;
                  end
                  default: ph_q <= ph_q;
               endcase
            end
         end
         if (sck_fall) begin
            if (ph_q == PH_RDAT || ph_q == PH_RDSR) begin
               if (bit_q == 3'd0) begin
                  so_q <= src_byte[7];
                  tx_q <= {src_byte[6:0], 1'b0};
               end else begin
                  so_q <= tx_q[7];
                  tx_q <= {tx_q[6:0], 1'b0};
               end
            end else begin
               so_q <= 1'b0;
            end
         end
      end
   end

   // R5
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && !cs_hi && (ph_q == PH_RDAT || ph_q == PH_WDAT))
         |=> addr_q == $past(addr_q) + 16'd1);

   // R3
   bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_hi |=> bit_q == 3'd0);

   // R2
   wel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel_q) |-> ($past(ph_q) == PH_CMD && $past(sck_rise)));

   // R8
   stat_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & 8'h71) == 8'h00);

   // R4
   so_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sck_fall && !cs_hi) |=> $stable(so_q));
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
   parameter int MEM_AW      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sck,
   input  logic        cs_n,
   input  logic        si,
   output logic        so,
   output logic        so_oe,
   output logic [15:0] chk_addr,
   input  logic        wr_permit,
   output logic [7:0]  stat_q
);
   logic [2:0] pins_s;
   logic       sck_s, cs_s, si_s, sck_d;
   logic       sck_rise, sck_fall;
   logic       mem_we, so_bit;
   logic [MEM_AW-1:0] mem_addr;
   logic [7:0] mem_wdata, rd_byte;

   spi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
      .clk(clk), .rst_n(rst_n), .din({sck, cs_n, si}), .dout(pins_s));

   assign {sck_s, cs_s, si_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;

   assign sck_rise = sck_s && !sck_d && !cs_s;
   assign sck_fall = !sck_s && sck_d && !cs_s;

   spi_cmd_engine #(.MEM_AW(MEM_AW)) i_eng (
      .clk(clk), .rst_n(rst_n), .cs_hi(cs_s), .sck_rise(sck_rise),
      .sck_fall(sck_fall), .si_bit(si_s), .rd_byte(rd_byte),
      .wr_permit(wr_permit), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .chk_addr(chk_addr), .so_bit(so_bit),
      .stat_q(stat_q));

   spi_mem_array #(.AW(MEM_AW), .DW(8)) i_mem (
      .clk(clk), .we(mem_we), .addr(mem_addr), .wdata(mem_wdata),
      .rdata(rd_byte));

   assign so_oe = !cs_s;
   assign so    = so_oe ? so_bit : 1'bz;

   // R10
   so_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !so_oe);
endmodule

// File: tb/test_serial_mem_slave.sv
`timescale 1ns/1ps
module test_serial_mem_slave;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0;
   logic cs_n = 1'b1;
   logic si = 1'b0;
   wire  so;
   wire  so_oe;
   wire [15:0] chk_addr;
   wire [7:0]  stat_q;
   wire        wr_permit;

   int checks = 0;
   int errors = 0;

   assign wr_permit = (chk_addr[15:8] != 8'h01);

   always #2.5 clk = ~clk;

   serial_mem_slave i_serial_mem_slave (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
      .so_oe(so_oe), .chk_addr(chk_addr), .wr_permit(wr_permit),
      .stat_q(stat_q));

   localparam logic [23:0] VEC [6] = '{
      {16'h0004, 8'hA5}, {16'h0255, 8'h5A}, {16'h03FF, 8'hC3},
      {16'h0280, 8'h0F}, {16'h0311, 8'hF0}, {16'h0077, 8'h81}
   };

   task automatic check(input logic [31:0] act, input logic [31:0] exp,
                        input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic xbits(input logic [7:0] tx, input int n,
                        output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - n; i--) begin
         si = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = so;
         sck = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0;
      end
   endtask

   task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
      xbits(tx, 8, rx);
   endtask

   task automatic fbegin();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic fend();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (2 * HALF) @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] op);
      logic [7:0] d;
      fbegin(); xbyte(op, d); fend();
   endtask

   task automatic wr_burst(input logic [15:0] a, input logic [31:0] dat,
                           input int n);
      logic [7:0] d;
      fbegin();
      xbyte(8'h02, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
      for (int i = 0; i < n; i++) xbyte(dat[8*(n-1-i) +: 8], d);
      fend();
   endtask

   task automatic rd_burst(input logic [15:0] a, input int n,
                           input logic [7:0] fill, output logic [31:0] r);
      logic [7:0] d;
      r = '0;
      fbegin();
      xbyte(8'h03, d); xbyte(a[15:8], d); xbyte(a[7:0], d);
      for (int i = 0; i < n; i++) begin
         xbyte(fill, d);
         r = {r[23:0], d};
      end
      fend();
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      logic [7:0]  d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R10 R8: reset state
      check({31'd0, so_oe}, 32'd0, "R10 reset so_oe");
      check({24'd0, stat_q}, 32'h00, "R8 reset status");

      // R9 R2: status repeats after set write enable
      cmd(8'h06);
      fbegin();
      check({31'd0, so_oe}, 32'd1, "R10 so_oe in frame");
      xbyte(8'h05, d);
      r = '0;
      for (int i = 0; i < 3; i++) begin
         xbyte(8'h00, d);
         r = {r[23:0], d};
      end
      fend();
      check(r, 32'h00020202, "R9 repeated status");

      // R1 R4: vector table
      for (int i = 0; i < 6; i++) wr_burst(VEC[i][23:8], {24'd0, VEC[i][7:0]}, 1);
      for (int i = 0; i < 6; i++) begin
         rd_burst(VEC[i][23:8], 1, 8'h00, r);
         check(r, {24'd0, VEC[i][7:0]}, "R4 table read");
      end

      // R2: write with latch clear is dropped
      cmd(8'h04);
      check({24'd0, stat_q}, 32'h00, "R1 clear enable");
      wr_burst(16'h0004, 32'hEE, 1);
      rd_burst(16'h0004, 1, 8'h00, r);
      check(r, 32'hA5, "R2 write without enable");

      // R5 R3: burst across FFFF
      cmd(8'h06);
      wr_burst(16'hFFFE, 32'h11223344, 4);
      rd_burst(16'hFFFE, 4, 8'h00, r);
      check(r, 32'h11223344, "R5 burst wrap");
      rd_burst(16'h0000, 1, 8'h00, r);
      check(r, 32'h33, "R5 wrap to 0000");
      rd_burst(16'hFFFF, 2, 8'h00, r);
      check(r, 32'h2233, "R5 read wrap");
      // R6: alias of FFFE
      rd_burst(16'h03FE, 1, 8'h00, r);
      check(r, 32'h11, "R6 alias");

      // R7: denied bytes mid-burst
      wr_burst(16'h05FE, 32'h5A, 1);
      wr_burst(16'h01FE, 32'h778899, 3);
      rd_burst(16'h01FE, 1, 8'h00, r);
      check(r, 32'h5A, "R7 denied byte");
      rd_burst(16'h0200, 1, 8'h00, r);
      check(r, 32'h99, "R7 counter advances");

      // R3: partial byte discarded
      wr_burst(16'h0031, 32'h12, 1);
      fbegin();
      xbyte(8'h02, d); xbyte(8'h00, d); xbyte(8'h30, d); xbyte(8'h77, d);
      xbits(8'hFF, 5, d);
      fend();
      rd_burst(16'h0030, 2, 8'h00, r);
      check(r, 32'h7712, "R3 partial byte");

      // R1: unknown command ignores following bytes
      wr_burst(16'h0040, 32'h33, 1);
      fbegin();
      xbyte(8'h0B, d); xbyte(8'h02, d); xbyte(8'h00, d);
      xbyte(8'h40, d); xbyte(8'h99, d);
      fend();
      rd_burst(16'h0040, 1, 8'h00, r);
      check(r, 32'h33, "R1 unknown opcode");
      fbegin(); xbyte(8'hFF, d); xbyte(8'h04, d); fend();
      check({24'd0, stat_q}, 32'h02, "R1 ignored clear");

      // R4: input ignored during read data
      rd_burst(16'h0030, 2, 8'hFF, r);
      check(r, 32'h7712, "R4 si ignored");
      rd_burst(16'h0030, 2, 8'h00, r);
      check(r, 32'h7712, "R4 no write on read");

      // R8: status write
      fbegin(); xbyte(8'h01, d); xbyte(8'hFF, d); fend();
      check({24'd0, stat_q}, 32'h8E, "R8 status write");
      fbegin(); xbyte(8'h05, d); xbyte(8'h00, d); fend();
      check({24'd0, d}, 32'h8E, "R8 status read");
      cmd(8'h04);
      check({24'd0, stat_q}, 32'h8C, "R2 clear keeps bits");
      fbegin(); xbyte(8'h01, d); xbyte(8'h00, d); fend();
      check({24'd0, stat_q}, 32'h8C, "R8 locked status write");
      cmd(8'h06);
      fbegin(); xbyte(8'h01, d); xbyte(8'h00, d); fend();
      check({24'd0, stat_q}, 32'h02, "R8 status clear");

      // R10: idle after frames
      check({31'd0, so_oe}, 32'd0, "R10 idle so_oe");

      finish_run();
   end
endmodule